// File: doc/BRIEF.md
# Synchronized Event Counter with Coherent Snapshot

This block counts rising edges of an asynchronous input signal using a single internal system clock that runs faster than the input. The input first passes through a chain of synchronizing flip-flops. An edge detector in the system clock domain then turns each rising edge into a one-cycle count enable. The counter itself never runs on the external signal as a clock.

The count is split into a lower and an upper segment, so the full carry chain is never traversed in one cycle. The carry out of the lower segment passes through a register before the upper segment uses it. The lower segment's value is delayed by the same one cycle, so the concatenated value is always a consistent count.

A host may pulse a snapshot strobe at any time. The block then latches this aligned count into a holding register and raises a valid flag for one cycle. Counting goes on without interruption while this happens.

Top module: `evt_snap_counter`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears the count, the carry register, the alignment register, the synchronizer and the holding register. After the edge, `snap_value` is 0 and `snap_valid` is 0.
- R2: A rising edge of `evt_in` that is first sampled high at clock edge i increases the count by exactly one. The increase is included in a snapshot requested at edge s exactly when i <= s-4.
- R3: `snap_valid` is high for exactly the one cycle that follows each clock edge at which `snap_req` is sampled high, and it is low at all other times.
- R4: `snap_value` changes only at a clock edge that samples `snap_req` high. It holds its value between snapshots.
- R5: Snapshots do not disturb counting. Strobes on consecutive cycles each return the correct running count.
- R6: The upper segment advances one cycle after the lower segment wraps. Every snapshot taken in the cycles around a carry returns a coherent value, never a torn one.
- R7: The count wraps from all ones to zero and raises no flag.
- R8: A level held high or held low adds nothing to the count. A falling edge adds nothing to the count.
- R9: A reset clears an input edge that the synchronizer has already sampled but that has not yet reached the count. After reset the input is taken to be low, so a high level present after reset counts as one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be faster than the input's edge rate |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Asynchronous event input whose rising edges are counted |
| snap_req | input | 1 | Snapshot strobe, sampled at each clock edge |
| snap_value | output | CNT_W (32) | Count captured by the most recent snapshot |
| snap_valid | output | 1 | One-cycle pulse marking a newly captured value |

## Verification
A wrong synchronizer depth or a wrong edge detector shifts the count by one. This shows up in the first snapshot taken within four cycles of an input edge. It also shows up in every later snapshot, because the error never clears. A lost or mistimed carry register produces a torn value: the upper segment is one step off relative to the lower one. This appears at the first snapshot taken near a lower-segment wrap. The bench also runs a narrow-segment instance, which wraps every 16 events, so such a fault shows up within a few dozen input edges. A holding register that does not hold its value is visible in the cycle after any idle edge.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int DEF_CNT_W       = 32;
  localparam int DEF_LO_W        = 16;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int SYNC_STAGES = evt_cnt_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/seg_pipe_counter.sv
module seg_pipe_counter #(
  parameter int CNT_W = evt_cnt_pkg::DEF_CNT_W,
  parameter int LO_W  = evt_cnt_pkg::DEF_LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);
  localparam int HI_W = CNT_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lo_d_q;
  logic [HI_W-1:0] hi_q;
  logic            carry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      lo_d_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      lo_d_q  <= lo_q;
      carry_q <= inc & (&lo_q);
      if (inc) lo_q <= lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          hi_q <= '0;
    else if (carry_q) hi_q <= hi_q + 1'b1;
  end

  assign count_o = {hi_q, lo_d_q};
  assign carry_o = carry_q;
endmodule

// File: rtl/snap_hold.sv
module snap_hold #(
  parameter int W = evt_cnt_pkg::DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic [W-1:0] din,
  output logic [W-1:0] val_o,
  output logic         valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req;
      if (req) val_o <= din;
    end
  end
endmodule

// File: rtl/evt_snap_counter.sv
module evt_snap_counter #(
  parameter int CNT_W       = evt_cnt_pkg::DEF_CNT_W,
  parameter int LO_W        = evt_cnt_pkg::DEF_LO_W,
  parameter int SYNC_STAGES = evt_cnt_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_in,
  input  logic             snap_req,
  output logic [CNT_W-1:0] snap_value,
  output logic             snap_valid
);
  logic             rise;
  logic             pipe_carry;
  logic [CNT_W-1:0] aligned_cnt;

  evt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(evt_in), .rise_o(rise)
  );

  seg_pipe_counter #(.CNT_W(CNT_W), .LO_W(LO_W)) cnt_i (
    .clk(clk), .rst(rst), .inc(rise), .count_o(aligned_cnt), .carry_o(pipe_carry)
  );

  snap_hold #(.W(CNT_W)) hold_i (
    .clk(clk), .rst(rst), .req(snap_req), .din(aligned_cnt),
    .val_o(snap_value), .valid_o(snap_valid)
  );
endmodule

// File: rtl/evt_snap_counter_chk.sv
module evt_snap_counter_chk #(
  parameter int CNT_W = 32,
  parameter int LO_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             snap_req,
  input logic             snap_valid,
  input logic [CNT_W-1:0] snap_value,
  input logic             rise,
  input logic             carry,
  input logic [CNT_W-1:0] aligned
);
  a_r3_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    (snap_req && !rst) |=> snap_valid);

  a_r3_valid_only_on_req: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> !snap_valid);

  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !snap_valid) |-> $stable(snap_value));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (aligned == $past(aligned) || aligned == $past(aligned) + 1'b1));

  a_r8_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  a_r6_low_zero_after_carry: assert property (@(posedge clk) disable iff (rst)
    (carry && !rst) |=> (aligned[LO_W-1:0] == '0));

  a_r6_high_steps_after_carry: assert property (@(posedge clk) disable iff (rst)
    (carry && !rst) |=> (aligned[CNT_W-1:LO_W] == $past(aligned[CNT_W-1:LO_W]) + 1'b1));
endmodule

bind evt_snap_counter evt_snap_counter_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) chk_i (
  .clk(clk), .rst(rst), .snap_req(snap_req), .snap_valid(snap_valid),
  .snap_value(snap_value), .rise(rise), .carry(pipe_carry), .aligned(aligned_cnt)
);

// File: tb/evt_snap_counter_tb_top.sv
module evt_snap_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt = 1'b0;
  logic        snap = 1'b0;
  logic [31:0] big_val;
  logic        big_vld;
  logic [7:0]  sml_val;
  logic        sml_vld;

  int total_chk = 0;
  int bad_chk   = 0;

  always #4 clk = ~clk;

  evt_snap_counter dut_i (
    .clk(clk), .rst(rst), .evt_in(evt), .snap_req(snap),
    .snap_value(big_val), .snap_valid(big_vld)
  );

  evt_snap_counter #(.CNT_W(8), .LO_W(4)) dut_s (
    .clk(clk), .rst(rst), .evt_in(evt), .snap_req(snap),
    .snap_value(sml_val), .snap_valid(sml_vld)
  );

  // model: running total of sampled rises, and its history
  logic [31:0] tot, t1, t2, t3, t4, exp_val;
  logic        prev_lvl;

  function automatic logic [31:0] add_rise(input logic [31:0] cur, input logic lvl,
                                           input logic prv);
    return cur + {31'd0, (lvl & ~prv)};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // assumed to start at a negedge
  task automatic cyc(input logic lvl, input logic snp, input string req);
    evt  = lvl;
    snap = snp;
    @(posedge clk);
    if (rst) begin
      tot = 0; t1 = 0; t2 = 0; t3 = 0; t4 = 0; prev_lvl = 1'b0; exp_val = 0;
    end else begin
      if (snp) exp_val = t4;
      tot = add_rise(tot, lvl, prev_lvl);
      prev_lvl = lvl;
      t4 = t3; t3 = t2; t2 = t1; t1 = tot;
    end
    @(negedge clk);
    if (rst) begin
      chk(big_val == 0 && !big_vld, "R1", big_val, 0);
      chk(sml_val == 0 && !sml_vld, "R1", {24'd0, sml_val}, 0);
    end else begin
      chk(big_vld == snp, "R3", {31'd0, big_vld}, {31'd0, snp});
      chk(sml_vld == snp, "R3", {31'd0, sml_vld}, {31'd0, snp});
      chk(big_val == exp_val, snp ? req : "R4", big_val, exp_val);
      chk(sml_val == exp_val[7:0], snp ? req : "R4", {24'd0, sml_val}, {24'd0, exp_val[7:0]});
    end
  endtask

  bit wd_fired = 0;
  initial begin
    #(8 * 150000);
    wd_fired = 1;
    bad_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tot = 0; t1 = 0; t2 = 0; t3 = 0; t4 = 0; prev_lvl = 0; exp_val = 0;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R1");
    rst = 1'b0;
    // R8: held low, then held high long, then falling edge
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, "R8");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, "R8");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, "R8");
    // R2: latency window, snapshot every cycle after a single edge
    cyc(1'b1, 1'b0, "R2");
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b1, "R2");
    // R5/R6/R7: dense edges, snapshot every cycle (narrow instance carries and wraps)
    for (int e = 0; e < 600; e++) begin
      cyc(1'b0, 1'b1, "R6");
      cyc(1'b1, 1'b1, "R7");
    end
    // random phase: R2/R5
    for (int n = 0; n < 400; n++) begin
      automatic logic lv = 1'(n & 1);
      automatic int   hold = 2 + int'($urandom_range(0, 3));
      for (int h = 0; h < hold; h++)
        cyc(lv, ($urandom_range(0, 7) == 0), "R5");
    end
    // R9: edge sampled then reset before it reaches the count
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, "R9");
    cyc(1'b1, 1'b0, "R9");
    rst = 1'b1;
    cyc(1'b1, 1'b0, "R9");
    cyc(1'b0, 1'b0, "R9");
    rst = 1'b0;
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, "R9");
    cyc(1'b1, 1'b0, "R9");
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, "R9");
    if (!wd_fired) begin
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end
endmodule